// File: doc/BRIEF.md
# Touch Scan Mode Sequencer

This block sets the scan timing for a capacitive touch panel with several keys. A prescaler supplies a one-cycle millisecond tick. The sensing front end supplies one "touched" bit per key. After reset, the sequencer holds a blanking interval: it keeps all outputs low and ignores the panel. It then raises a settled flag and starts issuing scan strobes. The period of those strobes depends on whether the block is scanning at the slow, low-power rate or at the fast rate.

A strap input selects the rate. With the strap at 1, the block scans fast at all times. With the strap at 0, it starts at the slow rate. It moves to the fast rate when any key is touched, and returns to the slow rate only after the whole panel has been untouched for a long interval. While no key is touched, the block also asks the front end to recalibrate its baselines at a regular interval. That request is a single pulse issued together with a scan strobe.

Every time constant is a parameter counted in ticks. The defaults give 0.5 s of blanking, strobe periods of 60 ms and 160 ms, recalibration every 4 s, and an 8 s release interval before the rate drops back.

Top module: `touch_scan_seq`

## Requirements
- R1: After reset, `settled`, `scan_strobe`, `recal_req` and `fast_rate` stay low and key inputs have no effect until SETTLE_TICKS ticks have passed. `settled` then rises and stays high until the next reset.
- R2: With `fast_strap` = 1, `fast_rate` is high throughout the time `settled` is high, and it never drops back, however long the panel stays untouched.
- R3: `scan_strobe` is a one-cycle pulse issued only on a tick. Between two strobes at a steady rate there are exactly FAST_TICKS ticks when `fast_rate` = 1 and SLOW_TICKS ticks when `fast_rate` = 0.
- R4: With `fast_strap` = 0, any bit of `key_hit` high while settled makes `fast_rate` go high in the next cycle.
- R5: Once every key is released, `fast_rate` falls when the RELAX_TICKS-th tick arrives, provided no key is touched in between.
- R6: No `recal_req` is issued while any key is touched. On an idle panel at the slow rate, successive requests are spaced a multiple of SLOW_TICKS apart and fall within SLOW_TICKS of RECAL_TICKS.
- R7: A touch restarts both the recalibration interval and the release interval. After the last release, the first request comes between RECAL_TICKS+1 and RECAL_TICKS+FAST_TICKS ticks later. The rate falls exactly RELAX_TICKS ticks after that release.
- R8: `recal_req` is one cycle wide and is only ever high in the same cycle as `scan_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-cycle pulse per millisecond from a prescaler |
| fast_strap | input | 1 | 1 = always scan fast, 0 = low-power scanning with automatic promotion |
| key_hit | input | NKEYS | Per-key touch-detected bits from the front end |
| fast_rate | output | 1 | Scan rate select, 1 = fast |
| scan_strobe | output | 1 | One-cycle pulse that starts a scan |
| settled | output | 1 | Blanking interval after reset has ended |
| recal_req | output | 1 | One-cycle baseline recalibration request |

## Verification
The bench builds the block with 10 ticks of blanking, strobe periods of 3 and 8 ticks, recalibration every 20 ticks and a 30-tick release interval. It drives a tick every second clock. Scaled down this way, several recalibration intervals and full release timeouts fit into a few hundred cycles. The tick gating and the exact tick counts of each interval can therefore be measured directly, rather than only sampled once.

// File: rtl/touch_scan_seq.sv
module touch_scan_seq #(
  parameter int NKEYS        = 4,
  parameter int SETTLE_TICKS = 500,
  parameter int FAST_TICKS   = 60,
  parameter int SLOW_TICKS   = 160,
  parameter int RECAL_TICKS  = 4000,
  parameter int RELAX_TICKS  = 8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             fast_strap,
  input  logic [NKEYS-1:0] key_hit,
  output logic             fast_rate,
  output logic             scan_strobe,
  output logic             settled,
  output logic             recal_req
);
  localparam int SET_W = $clog2(SETTLE_TICKS + 1);
  localparam int PER_MAX = (FAST_TICKS > SLOW_TICKS) ? FAST_TICKS : SLOW_TICKS;
  localparam int PER_W = $clog2(PER_MAX + 1);
  localparam int RC_W  = $clog2(RECAL_TICKS + 1);
  localparam int RX_W  = $clog2(RELAX_TICKS + 1);

  logic [SET_W-1:0] settle_cnt;
  logic [PER_W-1:0] per_cnt;
  logic [RC_W-1:0]  recal_cnt;
  logic [RX_W-1:0]  relax_cnt;
  logic             promoted, rate_q, pending;

  wire             any_key    = settled & (|key_hit);
  wire [PER_W-1:0] period     = fast_rate ? PER_W'(FAST_TICKS) : PER_W'(SLOW_TICKS);
  wire             rate_chg   = fast_rate ^ rate_q;
  wire             strobe_due = settled & ms_tick & ~rate_chg & (per_cnt == period - 1'b1);

  assign fast_rate = settled & (fast_strap | promoted);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settled    <= 1'b0;
      settle_cnt <= '0;
    end else if (!settled && ms_tick) begin
      if (settle_cnt == SET_W'(SETTLE_TICKS - 1)) settled <= 1'b1;
      else settle_cnt <= settle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt     <= '0;
      rate_q      <= 1'b0;
      scan_strobe <= 1'b0;
    end else begin
      rate_q      <= fast_rate;
      scan_strobe <= strobe_due;
      if (!settled || rate_chg) per_cnt <= '0;
      else if (ms_tick) per_cnt <= strobe_due ? '0 : per_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      promoted  <= 1'b0;
      relax_cnt <= '0;
    end else if (any_key) begin
      promoted  <= 1'b1;
      relax_cnt <= '0;
    end else if (settled && ms_tick && promoted) begin
      if (relax_cnt == RX_W'(RELAX_TICKS - 1)) begin
        promoted  <= 1'b0;
        relax_cnt <= '0;
      end else relax_cnt <= relax_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recal_cnt <= '0;
      pending   <= 1'b0;
      recal_req <= 1'b0;
    end else begin
      recal_req <= strobe_due & pending & ~any_key;
      if (!settled || any_key) begin
        recal_cnt <= '0;
        pending   <= 1'b0;
      end else if (ms_tick && recal_cnt == RC_W'(RECAL_TICKS - 1)) begin
        recal_cnt <= '0;
        pending   <= 1'b1;
      end else begin
        if (ms_tick) recal_cnt <= recal_cnt + 1'b1;
        if (strobe_due) pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/touch_scan_seq_chk.sv
module touch_scan_seq_chk #(
  parameter int NKEYS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ms_tick,
  input logic             fast_strap,
  input logic [NKEYS-1:0] key_hit,
  input logic             fast_rate,
  input logic             scan_strobe,
  input logic             settled,
  input logic             recal_req
);
  AST_QUIET_BLANKING: assert property (@(posedge clk) disable iff (!rst_n)
    !settled |-> (!scan_strobe && !recal_req && !fast_rate)); // R1
  AST_SETTLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> settled); // R1
  AST_STRAP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && fast_strap) |-> fast_rate); // R2
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_strobe |=> !scan_strobe); // R3
  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_strobe) |-> $past(ms_tick)); // R3
  AST_PROMOTE_ON_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && (|key_hit)) |=> fast_rate); // R4
  AST_NO_RECAL_TOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recal_req) |-> ($past(key_hit) == '0)); // R6
  AST_RECAL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |-> scan_strobe); // R8
  AST_RECAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |=> !recal_req); // R8
endmodule

bind touch_scan_seq touch_scan_seq_chk #(.NKEYS(NKEYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .fast_strap(fast_strap),
  .key_hit(key_hit), .fast_rate(fast_rate), .scan_strobe(scan_strobe),
  .settled(settled), .recal_req(recal_req)
);

// File: tb/touch_scan_seq_bench.sv
module touch_scan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NK = 4;
  localparam int SET_T = 10, FAST_T = 3, SLOW_T = 8, RECAL_T = 20, RELAX_T = 30;

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0, fast_strap = 1'b0;
  logic [NK-1:0] key_hit = '0;
  logic fast_rate, scan_strobe, settled, recal_req;
  int tick_no = 0;
  int n_checks = 0, n_fails = 0;

  touch_scan_seq #(.NKEYS(NK), .SETTLE_TICKS(SET_T), .FAST_TICKS(FAST_T),
    .SLOW_TICKS(SLOW_T), .RECAL_TICKS(RECAL_T), .RELAX_TICKS(RELAX_T)) u_touch_scan_seq (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .fast_strap(fast_strap),
    .key_hit(key_hit), .fast_rate(fast_rate), .scan_strobe(scan_strobe),
    .settled(settled), .recal_req(recal_req));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) ms_tick <= ~ms_tick;
  always @(posedge clk) if (ms_tick) tick_no <= tick_no + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!scan_strobe);
  endtask

  task automatic wait_ticks(input int n);
    int t0;
    t0 = tick_no;
    while (tick_no < t0 + n) @(negedge clk);
  endtask

  task automatic measure_period(input int exp, input string req);
    int a;
    wait_strobe();
    wait_strobe();
    a = tick_no;
    wait_strobe();
    chk(tick_no - a == exp, req, tick_no - a, exp);
  endtask

  // R1: blanking after reset, touches ignored, settled after SET_T ticks
  task automatic t_settle(input bit strap);
    int t0;
    bit quiet = 1'b1;
    fast_strap = strap;
    rst_n = 1'b0;
    key_hit = 4'b0101;
    repeat (3) @(negedge clk);
    chk(!settled && !scan_strobe && !recal_req && !fast_rate, "R1 reset state",
        {settled, scan_strobe, recal_req, fast_rate}, 0);
    rst_n = 1'b1;
    t0 = tick_no;
    while (!settled) begin
      @(negedge clk);
      if (!settled && (scan_strobe || recal_req || fast_rate)) quiet = 1'b0;
      if (tick_no - t0 >= SET_T - 3) key_hit = '0;
    end
    chk(quiet, "R1 outputs quiet while blanking", 0, 1);
    chk(tick_no - t0 == SET_T, "R1 settle length", tick_no - t0, SET_T);
    repeat (4) @(negedge clk);
    chk(fast_rate == strap, "R1 touch during blanking ignored", fast_rate, strap);
  endtask

  // R3: slow strobe period
  task automatic t_slow();
    measure_period(SLOW_T, "R3 slow period");
  endtask

  // R6 / R8: idle recalibration spacing and alignment
  task automatic t_recal_idle();
    int a, d;
    do @(negedge clk); while (!recal_req);
    chk(scan_strobe, "R8 recal with strobe", scan_strobe, 1);
    a = tick_no;
    @(negedge clk);
    chk(!recal_req, "R8 recal single cycle", recal_req, 0);
    do @(negedge clk); while (!recal_req);
    d = tick_no - a;
    chk((d % SLOW_T == 0) && d >= RECAL_T - SLOW_T && d <= RECAL_T + SLOW_T,
        "R6 idle recal spacing", d, RECAL_T);
    chk(!fast_rate, "R6 idle stays slow", fast_rate, 0);
  endtask

  // R4 / R3 / R6: promotion on touch, fast period, no recal while held
  task automatic t_promote();
    bit seen = 1'b0;
    int t0;
    @(negedge clk);
    key_hit = 4'b1000;
    @(negedge clk);
    chk(fast_rate, "R4 promote on touch", fast_rate, 1);
    measure_period(FAST_T, "R3 fast period");
    t0 = tick_no;
    while (tick_no < t0 + 2 * RECAL_T) begin
      @(negedge clk);
      if (recal_req) seen = 1'b1;
    end
    chk(!seen, "R6 no recal while touched", seen, 0);
  endtask

  // R7 / R5: release restarts both intervals
  task automatic t_release();
    int t0, d;
    @(negedge clk);
    key_hit = '0;
    t0 = tick_no;
    do @(negedge clk); while (!recal_req);
    d = tick_no - t0;
    chk(d >= RECAL_T + 1 && d <= RECAL_T + FAST_T, "R7 first recal after release", d, RECAL_T + 1);
    do @(negedge clk); while (fast_rate);
    chk(tick_no - t0 == RELAX_T, "R5 return to slow", tick_no - t0, RELAX_T);
  endtask

  // R7: retouch inside the release window restarts it
  task automatic t_retouch();
    int t0;
    @(negedge clk);
    key_hit = 4'b0010;
    @(negedge clk);
    key_hit = '0;
    wait_ticks(RELAX_T - 8);
    key_hit = 4'b0001;
    repeat (2) @(negedge clk);
    key_hit = '0;
    t0 = tick_no;
    wait_ticks(RELAX_T - 5);
    chk(fast_rate, "R7 retouch keeps fast", fast_rate, 1);
    do @(negedge clk); while (fast_rate);
    chk(tick_no - t0 == RELAX_T, "R7 relax restart", tick_no - t0, RELAX_T);
  endtask

  // R2: strap forces fast with no return
  task automatic t_strap();
    bit dropped = 1'b0;
    int t0;
    @(negedge clk);
    fast_strap = 1'b1;
    @(negedge clk);
    chk(fast_rate, "R2 strap fast", fast_rate, 1);
    t0 = tick_no;
    while (tick_no < t0 + 2 * RELAX_T) begin
      @(negedge clk);
      if (!fast_rate) dropped = 1'b1;
    end
    chk(!dropped, "R2 no return with strap", dropped, 0);
    measure_period(FAST_T, "R2 strap period fast");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_settle(1'b0);
    t_slow();
    t_recal_idle();
    t_promote();
    t_release();
    t_retouch();
    t_strap();
    t_settle(1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule